// File: doc/BRIEF.md
# Block-Scoped Warp Barrier Unit

This unit gives the warps resident on one compute unit a barrier that covers a single thread block. Before any warp of a block reaches a barrier, the block's slot is registered with its thread count. The unit turns that count into a number of warps, rounding up, so that the padded, inactive lanes of a partial last warp do not take part. When a warp executes a barrier instruction, it reports its own warp index and the slot of its block. Every warp that arrives before the last one is held by a stall bit. The last warp to arrive frees the whole block at once: the stall bits of all warps of that block drop, a release pulse names the slot, and the slot's arrival count returns to zero, ready for the next barrier in the same kernel.

Warps of other blocks are never held or freed by this barrier. A warp that arrives a second time while it is already held is reported on an error pulse and is otherwise ignored. An arrival for a slot that has no registered warps is also ignored.

Top module: `bsu_barrier_unit`

## Requirements
- R1: After reset, `stall_mask` is all zero and `release_valid` and `dup_error` are low.
- R2: A registered block of T threads needs ceil(T/LANES) warp arrivals before it is released. With LANES=32, a block of 65 threads needs 3 arrivals, and the second arrival does not release it.
- R3: A non-final accepted arrival of warp w sets bit w of `stall_mask` on the first clock edge after the arrival cycle.
- R4: On the edge after the final arrival of a block, `release_valid` is high for exactly one cycle and `release_slot` holds that block's slot. From that same cycle on, every `stall_mask` bit of that block's warps is zero.
- R5: A release clears no stall bit that belongs to a warp waiting on a different slot.
- R6: After a release, the slot's arrival count is back at zero, so the next barrier of the same block again needs the full warp count.
- R7: An arrival from a warp whose stall bit is already set raises `dup_error` for one cycle on the next edge. It changes neither the stall mask nor the count.
- R8: An arrival for a slot whose registered warp count is zero, or for a slot that is being registered in that same cycle, is ignored. It sets no stall bit and gives no release.
- R9: A block of one warp is released on the edge after its single arrival, and its stall bit is never set.
- R10: A thread count that is an exact multiple of LANES adds no extra warp: with LANES=32, 64 threads are released on the second arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register a block in a slot this cycle |
| reg_slot | input | SLOT_W | Slot being registered |
| reg_threads | input | THR_W | Thread count of the registered block |
| arr_valid | input | 1 | A warp executes a barrier this cycle |
| arr_warp | input | WARP_W | Index of the arriving warp |
| arr_slot | input | SLOT_W | Block slot of the arriving warp |
| stall_mask | output | NUM_WARPS | One bit per warp, set while the warp waits at a barrier |
| release_valid | output | 1 | One-cycle pulse when a block's barrier completes |
| release_slot | output | SLOT_W | Slot released with the pulse |
| dup_error | output | 1 | One-cycle pulse for a repeated arrival from a waiting warp |

## Verification
Blocks are registered with 65 threads (a padded last warp), 64 threads (an exact multiple), 40 threads and 20 threads (a single warp). This separates a rounding-up warp count from plain truncation, and separates an immediate release from a held one. Two blocks are left waiting at the same time, so a release that wipes the whole mask can be told apart from one that clears only its own block. The same block passes a second barrier to show that its count was cleared. A duplicate arrival and an arrival to an empty slot are placed where a wrong count would either trigger a release too early or hold a warp that should not be held.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
   localparam int unsigned MaxSlots = 32;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/bsu_warp_calc.sv
module bsu_warp_calc #(
   parameter int unsigned THR_W = 11,
   parameter int unsigned CNT_W = 6,
   parameter int unsigned LANES = 32
) (
   input  logic [THR_W-1:0] threads,
   output logic [CNT_W-1:0] warps
);
   localparam int unsigned LOG_L = (LANES > 1) ? $clog2(LANES) : 0;

   generate
      if (LANES == 1) begin : g_unit
         assign warps = CNT_W'(threads);
      end else begin : g_round
         logic [THR_W:0] padded;
         assign padded = {1'b0, threads} + (THR_W+1)'(LANES - 1);
         assign warps  = CNT_W'(padded >> LOG_L);
      end
   endgenerate
endmodule

// File: rtl/bsu_slot_bank.sv
module bsu_slot_bank #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned SLOT_W    = 3,
   parameter int unsigned CNT_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic [SLOT_W-1:0] reg_slot,
   input  logic [CNT_W-1:0]  reg_warps,
   input  logic [SLOT_W-1:0] look_slot,
   output logic              look_live,
   input  logic              hit_en,
   input  logic [SLOT_W-1:0] hit_slot,
   output logic              fire
);
   localparam int unsigned PAD = 1 << SLOT_W;

   logic [PAD-1:0]       live_vec;
   logic [NUM_SLOTS-1:0] fire_vec;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic [CNT_W-1:0] target_q;
         logic [CNT_W-1:0] count_q;
         logic             hit;
         logic             last;

         assign hit         = hit_en && (hit_slot == SLOT_W'(s));
         assign last        = (CNT_W'(count_q + 1'b1) == target_q);
         assign fire_vec[s] = hit && last;
         assign live_vec[s] = (target_q != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               target_q <= '0;
               count_q  <= '0;
            end else if (reg_en && reg_slot == SLOT_W'(s)) begin
               target_q <= reg_warps;
               count_q  <= '0;
            end else if (hit) begin
               count_q <= last ? '0 : CNT_W'(count_q + 1'b1);
            end
         end

         a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (target_q == '0) ? (count_q == '0) : (count_q < target_q));
      end
      for (genvar p = NUM_SLOTS; p < PAD; p++) begin : g_pad
         assign live_vec[p] = 1'b0;
      end
   endgenerate

   assign look_live = live_vec[look_slot];
   assign fire      = |fire_vec;
endmodule

// File: rtl/bsu_stall_track.sv
module bsu_stall_track #(
   parameter int unsigned NUM_WARPS = 16,
   parameter int unsigned WARP_W    = 4,
   parameter int unsigned SLOT_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [WARP_W-1:0]    set_warp,
   input  logic [SLOT_W-1:0]    set_slot,
   input  logic                 clr_en,
   input  logic [SLOT_W-1:0]    clr_slot,
   output logic [NUM_WARPS-1:0] stall_q
);
   logic [NUM_WARPS-1:0] own_hit;

   generate
      for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
         logic [SLOT_W-1:0] owner_q;

         assign own_hit[w] = (owner_q == clr_slot);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stall_q[w] <= 1'b0;
               owner_q    <= '0;
            end else if (clr_en && own_hit[w]) begin
               stall_q[w] <= 1'b0;
            end else if (set_en && set_warp == WARP_W'(w)) begin
               stall_q[w] <= 1'b1;
               owner_q    <= set_slot;
            end
         end

         a_r3_set_source: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stall_q[w]) |-> $past(set_en && set_warp == WARP_W'(w)));
         a_r4_drop_on_release: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stall_q[w]) |-> $past(clr_en));
      end
   endgenerate

   a_r4_block_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> ((stall_q & $past(own_hit)) == '0));
endmodule

// File: rtl/bsu_barrier_unit.sv
module bsu_barrier_unit #(
   parameter int unsigned NUM_WARPS   = 16,
   parameter int unsigned NUM_SLOTS   = 8,
   parameter int unsigned LANES       = 32,
   parameter int unsigned MAX_THREADS = 1024,
   localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int unsigned WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int unsigned THR_W  = $clog2(MAX_THREADS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_valid,
   input  logic [SLOT_W-1:0]    reg_slot,
   input  logic [THR_W-1:0]     reg_threads,
   input  logic                 arr_valid,
   input  logic [WARP_W-1:0]    arr_warp,
   input  logic [SLOT_W-1:0]    arr_slot,
   output logic [NUM_WARPS-1:0] stall_mask,
   output logic                 release_valid,
   output logic [SLOT_W-1:0]    release_slot,
   output logic                 dup_error
);
   import bsu_pkg::*;

   localparam int unsigned MAX_WARPS = (MAX_THREADS + LANES - 1) / LANES;
   localparam int unsigned CNT_W     = $clog2(MAX_WARPS + 1) + 1;
   localparam int unsigned WPAD      = 1 << WARP_W;

   initial begin
      assert (is_pow2(LANES)) else $error("LANES must be a power of two");
      assert (NUM_SLOTS >= 1 && NUM_SLOTS <= MaxSlots) else $error("NUM_SLOTS out of range");
      assert (NUM_WARPS >= 1) else $error("NUM_WARPS must be at least one");
      assert (MAX_THREADS >= LANES) else $error("MAX_THREADS below one warp");
   end

   logic [CNT_W-1:0]     reg_warps;
   logic                 slot_live;
   logic                 fire;
   logic                 accept;
   logic                 held;
   logic [WPAD-1:0]      stall_pad;

   bsu_warp_calc #(.THR_W(THR_W), .CNT_W(CNT_W), .LANES(LANES)) u_calc (
      .threads (reg_threads),
      .warps   (reg_warps)
   );

   assign stall_pad = WPAD'(stall_mask);
   assign held      = stall_pad[arr_warp];
   assign accept    = arr_valid && !held && slot_live &&
                      !(reg_valid && reg_slot == arr_slot);

   bsu_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_en    (reg_valid),
      .reg_slot  (reg_slot),
      .reg_warps (reg_warps),
      .look_slot (arr_slot),
      .look_live (slot_live),
      .hit_en    (accept),
      .hit_slot  (arr_slot),
      .fire      (fire)
   );

   bsu_stall_track #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W), .SLOT_W(SLOT_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (accept && !fire),
      .set_warp (arr_warp),
      .set_slot (arr_slot),
      .clr_en   (fire),
      .clr_slot (arr_slot),
      .stall_q  (stall_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         release_valid <= 1'b0;
         release_slot  <= '0;
         dup_error     <= 1'b0;
      end else begin
         release_valid <= fire;
         if (fire) release_slot <= arr_slot;
         dup_error     <= arr_valid && held;
      end
   end

   a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(dup_error && release_valid));
   a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
      release_valid |-> $past(arr_valid));
   a_r7_err_no_stall_change: assert property (@(posedge clk) disable iff (!rst_n)
      dup_error |-> $stable(stall_mask) || $past(release_valid));
endmodule

// File: tb/sim_bsu_barrier_unit.sv
module sim_bsu_barrier_unit;
   localparam int unsigned NW = 16;
   localparam int unsigned NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic [2:0]  reg_slot = '0;
   logic [10:0] reg_threads = '0;
   logic        arr_valid = 1'b0;
   logic [3:0]  arr_warp = '0;
   logic [2:0]  arr_slot = '0;
   logic [15:0] stall_mask;
   logic        release_valid;
   logic [2:0]  release_slot;
   logic        dup_error;

   int total = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;
   int expq[$];

   always #10 clk = ~clk;

   bsu_barrier_unit #(.NUM_WARPS(NW), .NUM_SLOTS(NS), .LANES(32), .MAX_THREADS(1024)) u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_slot(reg_slot), .reg_threads(reg_threads),
      .arr_valid(arr_valid), .arr_warp(arr_warp), .arr_slot(arr_slot),
      .stall_mask(stall_mask), .release_valid(release_valid),
      .release_slot(release_slot), .dup_error(dup_error)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: every pulse must match the next expected event (kind*256+slot)
   always @(negedge clk) begin
      if (rst_n && (release_valid || dup_error)) begin
         int got;
         got = release_valid ? (256 + int'(release_slot)) : 512;
         if (expq.size() == 0) check(1'b0, "R4/R7 unexpected pulse", got, 0);
         else begin
            int want;
            want = expq.pop_front();
            check(got == want, "R4/R7 pulse", got, want);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         check(1'b0, "watchdog", cycles, 100000);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   task automatic register(input int slot, input int thr);
      @(negedge clk);
      reg_valid = 1'b1; reg_slot = 3'(slot); reg_threads = 11'(thr);
      @(negedge clk);
      reg_valid = 1'b0;
   endtask

   task automatic arrive(input int w, input int slot, input int ev);
      @(negedge clk);
      if (ev != 0) expq.push_back(ev);
      arr_valid = 1'b1; arr_warp = 4'(w); arr_slot = 3'(slot);
      @(negedge clk);
      arr_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(stall_mask == '0 && !release_valid && !dup_error, "R1 reset", stall_mask, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(stall_mask == '0, "R1 after reset", stall_mask, 0);

      // 65 threads -> 3 warps in slot 2
      register(2, 65);
      arrive(0, 2, 0);
      check(stall_mask == 16'h0001, "R3 first stall", stall_mask, 16'h0001);
      arrive(1, 2, 0);
      check(stall_mask == 16'h0003, "R2 no release at 2 of 3", stall_mask, 16'h0003);
      arrive(5, 2, 256 + 2);
      check(stall_mask == '0, "R4 block cleared", stall_mask, 0);
      check(release_valid && release_slot == 3'd2, "R4 pulse slot", release_slot, 2);
      @(negedge clk);
      check(!release_valid, "R4 single cycle", release_valid, 0);

      // 64 threads -> 2 warps slot 4; 40 threads -> 2 warps slot 1
      register(4, 64);
      register(1, 40);
      arrive(3, 4, 0);
      arrive(7, 1, 0);
      check(stall_mask == 16'h0088, "R3 two blocks waiting", stall_mask, 16'h0088);
      arrive(8, 1, 256 + 1);
      check(stall_mask == 16'h0008, "R5 other block kept", stall_mask, 16'h0008);
      arrive(3, 4, 512);
      check(stall_mask == 16'h0008 && !release_valid, "R7 dup ignored", stall_mask, 16'h0008);
      arrive(9, 4, 256 + 4);
      check(stall_mask == '0, "R10 exact multiple releases at 2", stall_mask, 0);

      // second barrier of slot 2
      arrive(0, 2, 0);
      arrive(1, 2, 0);
      check(stall_mask == 16'h0003, "R6 count restarted", stall_mask, 16'h0003);
      arrive(5, 2, 256 + 2);
      check(stall_mask == '0, "R6 second release", stall_mask, 0);

      // unregistered slot 6
      arrive(10, 6, 0);
      check(stall_mask == '0 && !release_valid, "R8 empty slot ignored", stall_mask, 0);

      // arrival during registration of the same slot
      @(negedge clk);
      reg_valid = 1'b1; reg_slot = 3'd3; reg_threads = 11'd64;
      arr_valid = 1'b1; arr_warp = 4'd12; arr_slot = 3'd3;
      @(negedge clk);
      reg_valid = 1'b0; arr_valid = 1'b0;
      check(stall_mask == '0, "R8 same-cycle registration ignored", stall_mask, 0);
      arrive(12, 3, 0);
      check(stall_mask == 16'h1000, "R8 count untouched by ignored arrival", stall_mask, 16'h1000);
      arrive(13, 3, 256 + 3);
      check(stall_mask == '0, "R8 release at full count", stall_mask, 0);

      // single-warp block
      register(0, 20);
      arrive(11, 0, 256 + 0);
      check(stall_mask == '0 && release_valid, "R9 immediate release", stall_mask, 0);

      repeat (3) @(negedge clk);
      check(expq.size() == 0, "R4/R7 all events seen", expq.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule